// File: doc/BRIEF.md
# Board System Configuration Register Block

This block is the system-control register file of an FPGA board. A host reaches it through a simple single-cycle register port. The port carries a 12-bit byte offset into a 4 KB window, a write strobe, a read strobe, 32-bit write data and combinational read data. The block holds two general configuration words. The low byte of the second word lights eight board LEDs. The block also returns a fixed board word and two identity words, and reports eight DLL lock indications together with a software-writable lock mask.

The block also runs an indirect configuration channel into a small table of oscillator frequency settings. Software loads the outgoing data word first. It then writes the channel control word with the start bit set, a function number, a device number and a direction bit. The transaction finishes within that single write. The status word then shows done, and shows error when the function is not 1 or the device lies outside the table. A successful read places the selected entry in the returned-data word.

Top module: `brd_sysctl_regs`

## Requirements
- R1: After reset, config 0 (0x000), config 1 (0x004), returned data (0x0A0), outgoing data (0x0A4) and channel status (0x0AC) read 0. Channel control (0x0A8) reads 0x0010_0000 and DLL (0x100) has mask bits [31:24] equal to 0xFF.
- R2: Config 0, config 1 and outgoing data store a full 32-bit write and read it back unchanged.
- R3: Channel control holds device in bits [11:0], function in bits [25:20], write-not-read in bit 30 and start in bit 31. A write stores the value with bits [19:12], [29:26] and 31 cleared, so the readback equals the written value ANDed with 0x43F0_0FFF.
- R4: Every write to channel control clears the whole status word. A write with start clear leaves the status at 0 and starts nothing.
- R5: A write to channel control with start set makes status bit 0 (done) read 1 at once afterwards. Status bit 1 (error) reads 1 exactly when the function is not 1 or the device number is 3 or more.
- R6: A valid write transaction copies outgoing data into oscillator entry [device]. A valid read transaction copies that entry into returned data. A failed read leaves returned data unchanged, and a failed write changes no entry.
- R7: Oscillator entries 0, 1 and 2 reset to 50_000_000, 24_576_000 and 25_000_000.
- R8: A DLL write changes only mask bits [31:24]. Bits [23:16] read the 8-bit lock input and bits [15:1] read 0.
- R9: DLL bit 0 reads 1 exactly when every lock bit whose mask bit is set is 1.
- R10: Config 3 (0x00C) reads 0. Config 4 (0x010), auxiliary ID (0xFF8) and ID (0xFFC) read their parameter values. Writes to these offsets, to returned data and to status are ignored.
- R11: The LED outputs equal config 1 bits [7:0]; LED bit 7 is the leftmost lamp.
- R12: A read from any unmapped offset, unaligned ones included, returns 0, and a write there changes nothing. The bad-access output is 1 during the cycle after any unmapped read or write and 0 after a mapped one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| dll_lock_i | input | 8 | Lock indication of each DLL |
| led_o | output | 8 | LED drive, bit 7 leftmost |
| bad_access_o | output | 1 | One-cycle flag after an unmapped access |

## Verification
The assertions assume that read and write strobes are never asserted together. They also assume that address and write data are steady while a strobe is high. The bench meets this by changing inputs only on the falling clock edge. Each task drives exactly one strobe for one cycle and then leaves a full idle cycle before the next access. The lock input changes only between accesses, so the combinational DLL word is sampled while it is stable.

// File: rtl/brd_sysctl_pkg.sv
package brd_sysctl_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int LED_W   = 8;
  localparam int DLL_N   = 8;

  // Byte offsets of the mapped words
  localparam logic [ADDR_W-1:0] OFS_CFG0  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CFG1  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CFG3  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_CFG4  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_RTN   = 12'h0A0;
  localparam logic [ADDR_W-1:0] OFS_OUT   = 12'h0A4;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h0A8;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h0AC;
  localparam logic [ADDR_W-1:0] OFS_DLL   = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_AUXID = 12'hFF8;
  localparam logic [ADDR_W-1:0] OFS_ID    = 12'hFFC;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CFG0, SEL_CFG1, SEL_CFG3, SEL_CFG4, SEL_RTN,
    SEL_OUT, SEL_CTRL, SEL_STAT, SEL_DLL, SEL_AUXID, SEL_ID
  } reg_sel_e;

  // Channel control word layout
  typedef struct packed {
    logic        start;
    logic        wr;
    logic [3:0]  rsv_hi;
    logic [5:0]  func;
    logic [7:0]  rsv_lo;
    logic [11:0] dev;
  } chan_ctrl_t;

  localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h43F0_0FFF;
  localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0010_0000;
  localparam logic [5:0]        CHAN_FUNC  = 6'd1;

  function automatic logic all_masked_locked(input logic [DLL_N-1:0] mask,
                                             input logic [DLL_N-1:0] lock);
    return &(lock | ~mask);
  endfunction

  function automatic logic [DATA_W-1:0] dll_word(input logic [DLL_N-1:0] mask,
                                                 input logic [DLL_N-1:0] lock);
    return {mask, lock, 15'd0, all_masked_locked(mask, lock)};
  endfunction

  function automatic logic chan_target_bad(input logic [5:0]  func,
                                           input logic [11:0] dev,
                                           input int unsigned entries);
    return (func != CHAN_FUNC) || (32'(dev) >= entries);
  endfunction
endpackage

// File: rtl/brd_sysctl_dec.sv
module brd_sysctl_dec
  import brd_sysctl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              mapped
);
  always_comb begin
    unique case (addr)
      OFS_CFG0:  sel = SEL_CFG0;
      OFS_CFG1:  sel = SEL_CFG1;
      OFS_CFG3:  sel = SEL_CFG3;
      OFS_CFG4:  sel = SEL_CFG4;
      OFS_RTN:   sel = SEL_RTN;
      OFS_OUT:   sel = SEL_OUT;
      OFS_CTRL:  sel = SEL_CTRL;
      OFS_STAT:  sel = SEL_STAT;
      OFS_DLL:   sel = SEL_DLL;
      OFS_AUXID: sel = SEL_AUXID;
      OFS_ID:    sel = SEL_ID;
      default:   sel = SEL_NONE;
    endcase
  end

  assign mapped = (sel != SEL_NONE);
endmodule

// File: rtl/brd_sysctl_dll.sv
module brd_sysctl_dll
  import brd_sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [DLL_N-1:0]  mask_wdata,
  input  logic [DLL_N-1:0]  lock_i,
  output logic [DATA_W-1:0] dll_q
);
  logic [DLL_N-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign dll_q = dll_word(mask_q, lock_i);

  // R8: the mask moves only on a DLL write
  a_r8_mask_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/brd_sysctl_chan.sv
module brd_sysctl_chan
  import brd_sysctl_pkg::*;
#(
  parameter int unsigned NUM_OSC = 3,
  parameter logic [NUM_OSC-1:0][DATA_W-1:0] OSC_RESET =
    {32'd25_000_000, 32'd24_576_000, 32'd50_000_000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              out_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] rtn_q,
  output logic [DATA_W-1:0] out_q
);
  chan_ctrl_t        req;
  logic              chan_fire;
  logic              chan_err;
  logic              chan_wr_ok;
  logic              chan_rd_ok;
  logic [DATA_W-1:0] osc_q [NUM_OSC];
  logic [DATA_W-1:0] osc_sel;

  assign req        = chan_ctrl_t'(wdata);
  assign chan_fire  = ctrl_we && req.start;
  assign chan_err   = chan_target_bad(req.func, req.dev, NUM_OSC);
  assign chan_wr_ok = chan_fire && req.wr && !chan_err;
  assign chan_rd_ok = chan_fire && !req.wr && !chan_err;

  // Oscillator table, one register per entry
  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    logic hit;
    assign hit = chan_wr_ok && (32'(req.dev) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   osc_q[g] <= OSC_RESET[g];
      else if (hit) osc_q[g] <= out_q;
    end
  end

  always_comb begin
    osc_sel = '0;
    for (int i = 0; i < int'(NUM_OSC); i++)
      if (32'(req.dev) == i) osc_sel = osc_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      stat_q <= '0;
      rtn_q  <= '0;
      out_q  <= '0;
    end else begin
      if (out_we) out_q <= wdata;
      if (ctrl_we) begin
        ctrl_q <= wdata & CTRL_KEEP;
        stat_q <= {30'd0, chan_fire && chan_err, chan_fire};
      end
      if (chan_rd_ok) rtn_q <= osc_sel;
    end
  end

  // R5: done follows the start bit of the last control write
  a_r5_done_tracks_start: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> stat_q[0] == $past(wdata[31]));
  // R4: status changes only on a control write
  a_r4_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(stat_q));
  // R5: error never stands without done
  a_r5_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[1] |-> stat_q[0]);
  // R6: a failed read keeps the returned data
  a_r6_failed_read_keeps_rtn: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_fire && !req.wr && chan_err) |=> $stable(rtn_q));
  // R3: start is never stored
  a_r3_start_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> !ctrl_q[31]);
endmodule

// File: rtl/brd_sysctl_regs.sv
module brd_sysctl_regs
  import brd_sysctl_pkg::*;
#(
  parameter int unsigned     NUM_OSC   = 3,
  parameter logic [NUM_OSC-1:0][DATA_W-1:0] OSC_RESET =
    {32'd25_000_000, 32'd24_576_000, 32'd50_000_000},
  parameter logic [31:0]     CFG4_VAL  = 32'hC0DE_0004,
  parameter logic [31:0]     AUXID_VAL = 32'h0A17_0001,
  parameter logic [31:0]     ID_VAL    = 32'h4100_2F01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        dll_lock_i,
  output logic [7:0]        led_o,
  output logic              bad_access_o
);
  reg_sel_e          sel;
  logic              mapped;
  logic [DATA_W-1:0] cfg0_q, cfg1_q;
  logic [DATA_W-1:0] ctrl_q, stat_q, rtn_q, out_q, dll_q;
  logic              bad_q;
  logic              we_cfg0, we_cfg1, we_out, we_ctrl, we_dll;

  brd_sysctl_dec u_dec (.addr(bus_addr), .sel(sel), .mapped(mapped));

  assign we_cfg0 = bus_wr && (sel == SEL_CFG0);
  assign we_cfg1 = bus_wr && (sel == SEL_CFG1);
  assign we_out  = bus_wr && (sel == SEL_OUT);
  assign we_ctrl = bus_wr && (sel == SEL_CTRL);
  assign we_dll  = bus_wr && (sel == SEL_DLL);

  brd_sysctl_chan #(.NUM_OSC(NUM_OSC), .OSC_RESET(OSC_RESET)) u_chan (
    .clk(clk), .rst_n(rst_n), .ctrl_we(we_ctrl), .out_we(we_out),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .rtn_q(rtn_q), .out_q(out_q)
  );

  brd_sysctl_dll u_dll (
    .clk(clk), .rst_n(rst_n), .mask_we(we_dll),
    .mask_wdata(bus_wdata[31:24]), .lock_i(dll_lock_i), .dll_q(dll_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      if (we_cfg0) cfg0_q <= bus_wdata;
      if (we_cfg1) cfg1_q <= bus_wdata;
      bad_q <= (bus_wr || bus_rd) && !mapped;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CFG0:  bus_rdata = cfg0_q;
      SEL_CFG1:  bus_rdata = cfg1_q;
      SEL_CFG3:  bus_rdata = '0;
      SEL_CFG4:  bus_rdata = CFG4_VAL;
      SEL_RTN:   bus_rdata = rtn_q;
      SEL_OUT:   bus_rdata = out_q;
      SEL_CTRL:  bus_rdata = ctrl_q;
      SEL_STAT:  bus_rdata = stat_q;
      SEL_DLL:   bus_rdata = dll_q;
      SEL_AUXID: bus_rdata = AUXID_VAL;
      SEL_ID:    bus_rdata = ID_VAL;
      default:   bus_rdata = '0;
    endcase
  end

  assign led_o        = cfg1_q[LED_W-1:0];
  assign bad_access_o = bad_q;

  // R11: LEDs show the low byte of the last config 1 write
  a_r11_led_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    we_cfg1 |=> led_o == $past(bus_wdata[7:0]));
  // R12: a bad-access flag always has an access behind it
  a_r12_bad_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access_o |-> $past(bus_wr || bus_rd));
  // R12: unmapped addresses read zero
  a_r12_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == '0);
endmodule

// File: tb/tb_brd_sysctl_regs.sv
module tb_brd_sysctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  dll_lock_i = 8'hFF;
  logic [7:0]  led_o;
  logic        bad_access_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  localparam logic [31:0] E_CFG4 = 32'hC0DE_0004;
  localparam logic [31:0] E_AUX  = 32'h0A17_0001;
  localparam logic [31:0] E_ID   = 32'h4100_2F01;

  brd_sysctl_regs dut (.*);

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic bad);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bad = bad_access_o; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic bad);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bad = bad_access_o; bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input bit st, input bit w, input logic [5:0] f,
                                      input logic [11:0] dv);
    return {st, w, 4'd0, f, 8'd0, dv};
  endfunction

  task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d; logic b;
    rd(a, d, b);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    expect_rd("R1 cfg0", 12'h000, 0);
    expect_rd("R1 cfg1", 12'h004, 0);
    expect_rd("R1 rtn", 12'h0A0, 0);
    expect_rd("R1 out", 12'h0A4, 0);
    expect_rd("R1 ctrl", 12'h0A8, 32'h0010_0000);
    expect_rd("R1 stat", 12'h0AC, 0);
    expect_rd("R1 dll", 12'h100, 32'hFFFF_0001);
    check("R11 led reset", {24'd0, led_o}, 0);
  endtask

  task automatic t_plain;
    logic b;
    wr(12'h000, 32'hDEAD_BEEF, b); check("R12 mapped write no flag", {31'd0, b}, 0);
    wr(12'h004, 32'h1234_56A5, b);
    wr(12'h0A4, 32'hA5A5_5A5A, b);
    expect_rd("R2 cfg0", 12'h000, 32'hDEAD_BEEF);
    expect_rd("R2 cfg1", 12'h004, 32'h1234_56A5);
    expect_rd("R2 out", 12'h0A4, 32'hA5A5_5A5A);
    check("R11 led", {24'd0, led_o}, 32'hA5);
    check("R11 leftmost led bit7", {31'd0, led_o[7]}, 1);
  endtask

  task automatic t_osc_reset;
    logic b;
    logic [31:0] exp [3] = '{32'd50_000_000, 32'd24_576_000, 32'd25_000_000};
    for (int i = 0; i < 3; i++) begin
      wr(12'h0A8, ctl(1, 0, 6'd1, 12'(i)), b);
      expect_rd("R7 osc reset", 12'h0A0, exp[i]);
      expect_rd("R5 done only", 12'h0AC, 32'h1);
    end
  endtask

  task automatic t_chan_rw;
    logic b;
    wr(12'h0A4, 32'h0123_4567, b);
    wr(12'h0A8, ctl(1, 1, 6'd1, 12'd2), b);
    expect_rd("R5 write done", 12'h0AC, 32'h1);
    expect_rd("R3 ctrl start cleared", 12'h0A8, ctl(0, 1, 6'd1, 12'd2));
    wr(12'h0A8, ctl(1, 0, 6'd1, 12'd2), b);
    expect_rd("R6 read back entry 2", 12'h0A0, 32'h0123_4567);
    wr(12'h0A8, ctl(1, 0, 6'd1, 12'd1), b);
    expect_rd("R6 entry 1 untouched", 12'h0A0, 32'd24_576_000);
  endtask

  task automatic t_chan_err;
    logic b;
    wr(12'h0A8, ctl(1, 0, 6'd1, 12'd0), b);             // rtn = 50M
    wr(12'h0A8, ctl(1, 0, 6'd2, 12'd0), b);
    expect_rd("R5 bad function err", 12'h0AC, 32'h3);
    expect_rd("R6 failed read keeps rtn", 12'h0A0, 32'd50_000_000);
    wr(12'h0A8, ctl(1, 0, 6'd1, 12'd3), b);
    expect_rd("R5 device 3 err", 12'h0AC, 32'h3);
    wr(12'h0A8, ctl(0, 0, 6'd1, 12'd0), b);
    expect_rd("R4 no-start clears status", 12'h0AC, 32'h0);
    expect_rd("R4 no-start keeps rtn", 12'h0A0, 32'd50_000_000);
    wr(12'h0A4, 32'hFFFF_0000, b);
    wr(12'h0A8, 32'hFFFF_FFFF, b);
    expect_rd("R3 reserved masked", 12'h0A8, 32'h43F0_0FFF);
    expect_rd("R5 all-ones err", 12'h0AC, 32'h3);
    wr(12'h0A8, ctl(1, 1, 6'd0, 12'd1), b);
    expect_rd("R5 write bad func err", 12'h0AC, 32'h3);
    for (int i = 0; i < 3; i++) begin
      wr(12'h0A8, ctl(1, 0, 6'd1, 12'(i)), b);
      expect_rd("R6 failed write no change", 12'h0A0,
                i == 0 ? 32'd50_000_000 : i == 1 ? 32'd24_576_000 : 32'h0123_4567);
    end
  endtask

  task automatic t_dll;
    logic b;
    @(negedge clk); dll_lock_i = 8'h0F;
    expect_rd("R9 mask all, lock partial", 12'h100, 32'hFF0F_0000);
    wr(12'h100, 32'h0F12_3456, b);
    expect_rd("R8 only mask written", 12'h100, 32'h0F0F_0001);
    @(negedge clk); dll_lock_i = 8'h0E;
    expect_rd("R9 masked bit unlocked", 12'h100, 32'h0F0E_0000);
    wr(12'h100, 32'h00FF_FFFF, b);
    expect_rd("R9 empty mask locked", 12'h100, 32'h000E_0001);
  endtask

  task automatic t_readonly;
    logic b;
    wr(12'h00C, 32'hFFFF_FFFF, b);
    wr(12'h010, 32'h1111_1111, b);
    wr(12'hFF8, 32'h2222_2222, b);
    wr(12'hFFC, 32'h3333_3333, b);
    wr(12'h0A0, 32'h4444_4444, b);
    wr(12'h0AC, 32'h5555_5555, b);
    expect_rd("R10 cfg3 zero", 12'h00C, 0);
    expect_rd("R10 cfg4", 12'h010, E_CFG4);
    expect_rd("R10 auxid", 12'hFF8, E_AUX);
    expect_rd("R10 id", 12'hFFC, E_ID);
    expect_rd("R10 rtn not writable", 12'h0A0, 32'h0123_4567);
    expect_rd("R10 stat not writable", 12'h0AC, 32'h1);
  endtask

  task automatic t_unmapped;
    logic b; logic [31:0] d;
    wr(12'h008, 32'hFFFF_FFFF, b);
    check("R12 write flag", {31'd0, b}, 1);
    rd(12'h008, d, b);
    check("R12 read zero", d, 0); check("R12 read flag", {31'd0, b}, 1);
    rd(12'h002, d, b);
    check("R12 unaligned zero", d, 0); check("R12 unaligned flag", {31'd0, b}, 1);
    wr(12'h005, 32'h0000_0000, b);
    expect_rd("R12 unaligned write ignored", 12'h004, 32'h1234_56A5);
    rd(12'h000, d, b);
    check("R12 mapped read no flag", {31'd0, b}, 0);
    check("R12 cfg0 unchanged", d, 32'hDEAD_BEEF);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_osc_reset();
    t_chan_rw();
    t_chan_err();
    t_dll();
    t_readonly();
    t_unmapped();
    finish_run();
  end
endmodule